// File: doc/BRIEF.md
# GPIO Bank Controller with Pin Event Interrupts

This block controls one bank of general-purpose pins through a small memory-mapped register bus. Software sets the value each pin drives, which pins actually drive, and reads back the pin levels. Every pin input passes through a two-flop synchroniser. The synchronised level is what software reads, and it also feeds a per-pin event detector.

Each pin can raise an interrupt on a rising edge, a falling edge, a high level or a low level. The events collect in a sticky status register. One bank interrupt line is raised while any status bit is set whose enable bit is also set. Every register can be accessed at three offsets: a replace offset, an OR-in offset and a clear-bits offset. Software can therefore change single bits without a read-modify-write sequence.

Top module: `pinbank_top`

## Requirements
- R1: After reset, every register reads 0, `pinOe` is 0 and `irqOut` is 0.
- R2: Register index i (0..7) sits at byte offset 0x10*i. Index 0 is output data, 1 is input data, 2 is output enable, 3 is pin select, 4 is enable, 5 is level/edge, 6 is polarity and 7 is status. A write to offset +0x0 replaces the register with `busWdata`.
- R3: A write to offset +0x4 ORs `busWdata` into the register.
- R4: A write to offset +0x8 clears each register bit whose `busWdata` bit is 1. Reads at any of the three offsets return the register.
- R5: The input-data register holds `pinIn` after two clock edges. It does not show the new value after one edge. Writes to it are ignored.
- R6: `pinOe` equals the output-enable register. `pinOut` equals output data AND output enable.
- R7: When level bit = 0 (edge mode), the pin's status bit is set on a rising edge of the synchronised input if polarity = 1, and on a falling edge if polarity = 0. The bit is readable on the third clock edge after the pin changes.
- R8: When level bit = 1 (level mode), the status bit is set on every cycle the synchronised pin equals the polarity bit. A clear written while that level persists leaves the bit at 1.
- R9: A pin whose pin-select bit is 0 never sets its status bit.
- R10: Status bits stay set until software writes them. Once the pin condition goes away, the bit remains 1.
- R11: If a hardware event and a software clear hit the same status bit in one cycle, the bit ends at 1.
- R12: `irqOut` is 1 exactly when status AND enable is non-zero.
- R13: An address with bits [1:0] non-zero, bits [3:2] = 3, or any bit above bit 6 set is unmapped. Reads there return 0 and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busValid | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | NUM_PINS | Write data |
| busRdata | output | NUM_PINS | Read data, combinational, 0 when not reading |
| pinIn | input | NUM_PINS | Asynchronous pin levels |
| pinOut | output | NUM_PINS | Value driven on each pin |
| pinOe | output | NUM_PINS | Per-pin drive enable |
| irqOut | output | 1 | Combined bank interrupt |

## Verification
The status register has two writers in one cycle: the event detector sets bits and a software clear removes them. The bench provokes the collision by holding a pin at its active level in level mode and writing the clear offset. It then reads status on the very next cycle, where a clear that won would show as a one-cycle 0. A sweep over every pin and all four type codes applies rising and falling transitions with clears in between. Expected status and interrupt values are computed from the polarity and level bits.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  localparam int NUM_REGS = 8;
  localparam int IDX_W    = 3;

  localparam int REG_DOUT = 0;
  localparam int REG_DIN  = 1;
  localparam int REG_OE   = 2;
  localparam int REG_SEL  = 3;
  localparam int REG_EN   = 4;
  localparam int REG_LVL  = 5;
  localparam int REG_POL  = 6;
  localparam int REG_STAT = 7;

  typedef enum logic [1:0] {
    OP_PLAIN = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_NONE  = 2'd3
  } wrOp_e;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrSel;
    wrOp_e               op;
    logic                rdHit;
    logic [IDX_W-1:0]    rdIdx;
  } bankStb_t;

endpackage

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output bankStb_t          stb
);

  localparam int OP_LSB  = 2;
  localparam int IDX_LSB = 4;
  localparam int TOP_LSB = IDX_LSB + IDX_W;

  logic             mapped;
  logic [IDX_W-1:0] idx;
  wrOp_e            op;

  always_comb begin
    idx    = busAddr[IDX_LSB +: IDX_W];
    op     = wrOp_e'(busAddr[OP_LSB +: 2]);
    mapped = (busAddr[1:0] == 2'b00) && (op != OP_NONE) &&
             ((busAddr >> TOP_LSB) == '0);

    stb       = '0;
    stb.op    = op;
    stb.rdIdx = idx;
    stb.rdHit = busValid && !busWrite && mapped;
    if (busValid && busWrite && mapped && (int'(idx) != REG_DIN))
      stb.wrSel = NUM_REGS'(1) << idx;
  end

  always_comb begin
    AST_WRSEL_ONEHOT: assert ($onehot0(stb.wrSel)); // R13
  end

endmodule

// File: rtl/pinbank_dp.sv
module pinbank_dp
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  bankStb_t            stb,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irqOut
);

  function automatic logic [NUM_PINS-1:0] applyOp(
    input logic [NUM_PINS-1:0] cur,
    input logic [NUM_PINS-1:0] wd,
    input wrOp_e               op
  );
    case (op)
      OP_PLAIN: return wd;
      OP_SET:   return cur | wd;
      OP_CLR:   return cur & ~wd;
      default:  return cur;
    endcase
  endfunction

  // input synchroniser chain
  logic [NUM_PINS-1:0] syncStg [SYNC_STAGES];
  logic [NUM_PINS-1:0] syncOut;
  logic [NUM_PINS-1:0] prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncStg[s] <= '0;
      prevQ <= '0;
    end else begin
      syncStg[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncStg[s] <= syncStg[s-1];
      prevQ <= syncOut;
    end
  end

  assign syncOut = syncStg[SYNC_STAGES-1];

  // register file
  logic [NUM_PINS-1:0] regView [NUM_REGS];
  logic [NUM_PINS-1:0] statusQ;
  logic [NUM_PINS-1:0] eventVec;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gRegs
    if (g == REG_DIN) begin : gDin
      assign regView[g] = syncOut;
    end else if (g == REG_STAT) begin : gStat
      assign regView[g] = statusQ;
    end else begin : gCfg
      logic [NUM_PINS-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              q <= '0;
        else if (stb.wrSel[g])  q <= applyOp(q, busWdata, stb.op);
      end
      assign regView[g] = q;
    end
  end

  logic [NUM_PINS-1:0] doutQ, oeQ, selQ, enQ, lvlQ, polQ;
  assign doutQ = regView[REG_DOUT];
  assign oeQ   = regView[REG_OE];
  assign selQ  = regView[REG_SEL];
  assign enQ   = regView[REG_EN];
  assign lvlQ  = regView[REG_LVL];
  assign polQ  = regView[REG_POL];

  // event detection
  logic [NUM_PINS-1:0] riseVec, fallVec, edgeHit, levelHit;
  always_comb begin
    riseVec  = syncOut & ~prevQ;
    fallVec  = ~syncOut & prevQ;
    edgeHit  = ~lvlQ & ((polQ & riseVec) | (~polQ & fallVec));
    levelHit = lvlQ & ~(syncOut ^ polQ);
    eventVec = selQ & (edgeHit | levelHit);
  end

  logic statWr;
  assign statWr = stb.wrSel[REG_STAT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statWr ? applyOp(statusQ, busWdata, stb.op) : statusQ) | eventVec;
  end

  assign irqOut   = |(statusQ & enQ);
  assign pinOe    = oeQ;
  assign pinOut   = doutQ & oeQ;
  assign busRdata = stb.rdHit ? regView[stb.rdIdx] : '0;

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(statusQ) & ~statusQ)) |-> $past(statWr)); // R10

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    !(|($past(eventVec) & ~statusQ))); // R11

  AST_SEL_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusQ & ~$past(statusQ) & ~$past(selQ))) |-> $past(statWr)); // R9

endmodule

// File: rtl/pinbank_top.sv
module pinbank_top
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irqOut
);

  bankStb_t stb;

  pinbank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .stb      (stb)
  );

  pinbank_dp #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .irqOut   (irqOut)
  );

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && (busAddr[3:2] == 2'b11)) |-> (busRdata == '0)); // R13

endmodule

// File: tb/pinbank_top_bench.sv
module pinbank_top_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busValid, busWrite;
  logic [7:0]  busAddr;
  logic [31:0] busWdata, busRdata;
  logic [31:0] pinIn, pinOut, pinOe;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pinbank_top u_pinbank_top (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  function automatic logic [7:0] ad(input int idx, input int op);
    return 8'((idx << 4) | (op << 2));
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #1;
    check(tag, busRdata, exp);
    busValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, c;
    busValid = 0; busWrite = 0; busAddr = 0; busWdata = 0; pinIn = 0; rstN = 0;
    idle(3);
    rstN = 1;
    idle(1);

    // R1 reset state
    for (int i = 0; i < 8; i++) rdChk("R1 reset reg", ad(i, 0), 32'h0);
    check("R1 irq", {31'b0, irqOut}, 32'h0);
    check("R1 oe", pinOe, 32'h0);

    // R2 R3 R4 alias sweep over all writable registers
    a = 32'hA5A5_0F0F; b = 32'h0000_F0F1; c = 32'hFFFF_0000;
    for (int i = 0; i < 8; i++) begin
      if (i == 1) continue;
      wr(ad(i, 0), a);
      rdChk("R2 plain write", ad(i, 0), a);
      wr(ad(i, 1), b);
      rdChk("R3 set alias", ad(i, 1), a | b);
      wr(ad(i, 2), c);
      rdChk("R4 clear alias", ad(i, 2), (a | b) & ~c);
      wr(ad(i, 0), 32'h0);
      rdChk("R2 zero", ad(i, 0), 32'h0);
    end

    // R6 output gating
    wr(ad(0, 0), 32'hFFFF_0000);
    wr(ad(2, 0), 32'h00FF_00FF);
    check("R6 pinOut", pinOut, 32'h00FF_0000);
    check("R6 pinOe", pinOe, 32'h00FF_00FF);
    wr(ad(2, 0), 32'h0);
    check("R6 pinOut off", pinOut, 32'h0);

    // R13 unmapped
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    wr(8'h80, 32'hFFFF_FFFF);
    rdChk("R13 unmapped read 0x0C", 8'h0C, 32'h0);
    rdChk("R13 unmapped read 0x80", 8'h80, 32'h0);
    rdChk("R13 unmapped read 0x01", 8'h01, 32'h0);
    rdChk("R13 dout untouched", ad(0, 0), 32'hFFFF_0000);
    wr(ad(0, 0), 32'h0);

    // R5 input synchroniser
    pinIn = 32'h1234_5678;
    idle(1);
    rdChk("R5 one edge", ad(1, 0), 32'h0);
    idle(1);
    rdChk("R5 two edges", ad(1, 0), 32'h1234_5678);
    wr(ad(1, 0), 32'h0);
    rdChk("R5 write ignored", ad(1, 0), 32'h1234_5678);
    pinIn = 32'h0;
    idle(4);

    // R9 pin select gating, rising edge mode on pin 3
    wr(ad(6, 0), 32'h8);
    pinIn = 32'h8; idle(4); pinIn = 32'h0; idle(4);
    rdChk("R9 unselected", ad(7, 0), 32'h0);
    // R7 timing and R10 stickiness with selection on
    wr(ad(3, 0), 32'h8);
    wr(ad(4, 0), 32'h8);
    pinIn = 32'h8;
    idle(2);
    rdChk("R7 not yet", ad(7, 0), 32'h0);
    idle(1);
    rdChk("R7 third edge", ad(7, 0), 32'h8);
    pinIn = 32'h0; idle(10);
    rdChk("R10 sticky", ad(7, 0), 32'h8);
    check("R12 irq on", {31'b0, irqOut}, 32'h1);
    wr(ad(4, 2), 32'h8);
    check("R12 irq masked", {31'b0, irqOut}, 32'h0);
    wr(ad(7, 2), 32'hFFFF_FFFF);
    rdChk("R10 sw clear", ad(7, 0), 32'h0);
    wr(ad(3, 0), 32'h0); wr(ad(6, 0), 32'h0);

    // R11 set wins over clear: high level on pin 9
    wr(ad(5, 0), 32'h200); wr(ad(6, 0), 32'h200); wr(ad(3, 0), 32'h200);
    pinIn = 32'h200; idle(4);
    wr(ad(7, 2), 32'h200);
    rdChk("R11 set wins", ad(7, 0), 32'h200);
    wr(ad(3, 0), 32'h0); pinIn = 32'h0; idle(4);
    wr(ad(7, 2), 32'hFFFF_FFFF);
    wr(ad(5, 0), 32'h0); wr(ad(6, 0), 32'h0);

    // R7 R8 R12 sweep over all pins and the four type codes
    for (int p = 0; p < 32; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic lvl, pol;
        logic [31:0] bit_p, e0, e1, e2, e3, en;
        lvl = m[0]; pol = m[1];
        bit_p = 32'h1 << p;
        en = p[0] ? bit_p : 32'h0;
        wr(ad(3, 0), 32'h0);
        wr(ad(5, 0), lvl ? bit_p : 32'h0);
        wr(ad(6, 0), pol ? bit_p : 32'h0);
        wr(ad(4, 0), en);
        wr(ad(3, 0), bit_p);
        idle(4);
        wr(ad(7, 2), 32'hFFFF_FFFF);
        e0 = (lvl && !pol) ? bit_p : 32'h0;
        rdChk("R8 after clear low", ad(7, 0), e0);
        pinIn = bit_p; idle(4);
        e1 = e0 | (pol ? bit_p : 32'h0);
        rdChk("R7 rising", ad(7, 0), e1);
        wr(ad(7, 2), 32'hFFFF_FFFF);
        e2 = (lvl && pol) ? bit_p : 32'h0;
        rdChk("R8 after clear high", ad(7, 0), e2);
        pinIn = 32'h0; idle(4);
        e3 = e2 | (!pol ? bit_p : 32'h0);
        rdChk("R7 falling", ad(7, 0), e3);
        check("R12 irq sweep", {31'b0, irqOut}, {31'b0, |(e3 & en)});
        wr(ad(3, 0), 32'h0);
        wr(ad(7, 2), 32'hFFFF_FFFF);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule